// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Sequencer

This block decides when each gate pulse of a quasi-resonant flyback driver starts and ends. During the on-time it keeps two leading-edge windows for the current comparators and it caps the pulse length. It ends the pulse one cycle after an unblanked trip request from the peak-current comparator.

During the off-time it first waits out a blanking interval. It then watches the zero-crossing comparator for valleys of the drain ringing. At low line it turns the gate back on at the first valley. At high line it skips one valley and turns on at the second. If the second valley never shows up, a timeout stands in for it. If no zero-crossing activity arrives at all, for example at startup, a watchdog forces a pulse.

Around each gate edge the block raises a strobe that grounds the shared sense pin for a short time. Every duration is a clock-cycle parameter.

Top module: `qr_valley_seq`

## Requirements
- R1: While `rst_n` is low, `gate`, `pin_gnd`, `leb_cs` and `leb_stop` are all 0.
- R2: With the latched line range at low line, a valley ends the off-time. A valley is `zcd_above_lo` going from 1 to 0 on consecutive clock edges after the block has been armed. `gate` goes to 1 at the clock edge that samples the 0.
- R3: With the latched line range at high line, the first valley of an off-time does not start a pulse. The second valley does, with the same timing as in R2.
- R4: After `gate` falls, the block ignores both zero-crossing inputs for BLANK_NORM_CYC cycles. A valley attempt whose arming sample lands inside that window starts no pulse.
- R5: In startup mode the blanking lasts BLANK_START_CYC cycles. Reset enters startup mode, and so does a high sample of `startup_req`. The block leaves startup mode when `zcd_above_hi` is sampled high after blanking has ended.
- R6: At high line, after the first valley, `gate` rises TIMEOUT_CYC cycles after that valley if `zcd_above_lo` stays 0 the whole time.
- R7: If no valley occurs, `gate` rises WD_LL_CYC cycles after reset release or after `gate` falls. At high line the delay is WD_HL_CYC. Each valley restarts this delay.
- R8: `pin_gnd` is 1 for the first GND_ON_CYC cycles of every pulse and for the first GND_OFF_CYC cycles after every fall of `gate`.
- R9: A pulse with no trip request lasts exactly ON_MAX_CYC cycles.
- R10: `leb_cs` is 1 for the first LEB_CS_CYC cycles of a pulse and `leb_stop` for the first GND_ON_CYC cycles. A `cs_trip` held high from the start is ignored while `leb_cs` is 1 and then ends the pulse, giving a pulse of LEB_CS_CYC+1 cycles. After that, `gate` stays 0 until the next turn-on event.
- R11: `line_high` is sampled only at the clock edge where `gate` falls. Changing it during the off-time does not change that off-time's valley count or watchdog length.
- R12: A valley counts only if `zcd_above_hi` was sampled high after blanking and after the previous valley. A fall of `zcd_above_lo` without that arming starts no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_trip | input | 1 | Peak-current comparator asks for gate off |
| zcd_above_hi | input | 1 | Zero-crossing signal above the upper threshold |
| zcd_above_lo | input | 1 | Zero-crossing signal above the lower threshold |
| line_high | input | 1 | High-line range flag |
| startup_req | input | 1 | Enter startup mode (long blanking) |
| gate | output | 1 | Gate drive |
| pin_gnd | output | 1 | Sense pin grounding strobe |
| leb_cs | output | 1 | Blanking window for the cycle-by-cycle comparator |
| leb_stop | output | 1 | Short blanking window for the overshoot comparator |

## Verification
The hardest case to reach is the exact edge of the blanking interval. It matters most in startup mode, where the interval is longer and is left only by an arming sample that lands after blanking. The stimulus works from the observed falling edge of `gate`. It places the arming sample either on the last blanked cycle or on the first open cycle, so a one-cycle difference shows up as a pulse or no pulse. The high-line timeout is reached the same way: one valley is delivered at a known cycle, then the zero-crossing inputs are held low and the cycles to the next rise are counted.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_BLANK = 2'd1,
      ST_ON    = 2'd2
   } qrv_state_e;

   function automatic int unsigned qrv_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/qrv_on_timer.sv
module qrv_on_timer #(
   parameter int unsigned ON_MAX   = 4500,
   parameter int unsigned LEB_CS   = 34,
   parameter int unsigned LEB_STOP = 22
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on,
   input  logic off_req,
   output logic leb_cs,
   output logic leb_stop,
   output logic end_pulse
);
   localparam int unsigned CW = $clog2(ON_MAX + 1);
   localparam logic [CW-1:0] LAST_C = CW'(ON_MAX - 1);
   localparam logic [CW-1:0] LEB_C  = CW'(LEB_CS);

   logic [CW-1:0] cnt;

   if (LEB_CS == 0 || LEB_CS >= ON_MAX) begin : g_bad_leb
      $error("qrv_on_timer: LEB_CS must lie in 1..ON_MAX-1");
   end
   if (LEB_STOP > LEB_CS) begin : g_bad_stop
      $error("qrv_on_timer: LEB_STOP may not exceed LEB_CS");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt <= '0;
      else if (on) cnt <= cnt + CW'(1);
      else         cnt <= '0;
   end

   assign leb_cs = on && (cnt < LEB_C);

   if (LEB_STOP == 0) begin : g_no_stop
      assign leb_stop = 1'b0;
   end else begin : g_stop
      localparam logic [CW-1:0] STOP_C = CW'(LEB_STOP);
      assign leb_stop = on && (cnt < STOP_C);
      // R10
      stop_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
         leb_stop |-> leb_cs);
   end

   assign end_pulse = on && ((off_req && !leb_cs) || (cnt == LAST_C));

   // R9
   on_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on && cnt == LAST_C) |=> !on);

endmodule

// File: rtl/qrv_valley_det.sv
module qrv_valley_det #(
   parameter int unsigned VAL_LL  = 1,
   parameter int unsigned VAL_HL  = 2,
   parameter int unsigned TIMEOUT = 913
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic clr,
   input  logic hl,
   input  logic zcd_hi,
   input  logic zcd_lo,
   output logic valley,
   output logic fire
);
   localparam int unsigned VMAX = qrv_pkg::qrv_max(VAL_LL, VAL_HL);
   localparam int unsigned VW   = $clog2(VMAX + 1);
   localparam int unsigned TW   = $clog2(TIMEOUT + 1);
   localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT - 1);

   logic          prev_lo;
   logic          armed;
   logic [VW-1:0] vcnt;
   logic [VW-1:0] target;
   logic [TW-1:0] tocnt;
   logic          to_en;
   logic          fire_v;
   logic          fire_to;

   if (VAL_LL == 0 || VAL_HL == 0 || TIMEOUT == 0) begin : g_bad
      $error("qrv_valley_det: valley numbers and TIMEOUT must be nonzero");
   end

   if (VAL_LL == VAL_HL) begin : g_fixed
      assign target = VW'(VAL_LL);
   end else begin : g_sel
      assign target = hl ? VW'(VAL_HL) : VW'(VAL_LL);
   end

   assign valley  = en && armed && prev_lo && !zcd_lo;
   assign fire_v  = valley && (vcnt == target - VW'(1));
   assign to_en   = en && hl && (vcnt != '0);
   assign fire_to = to_en && !zcd_lo && (tocnt == TO_LAST);
   assign fire    = fire_v || fire_to;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lo <= 1'b0;
         armed   <= 1'b0;
         vcnt    <= '0;
         tocnt   <= '0;
      end else begin
         prev_lo <= zcd_lo;
         if (clr) begin
            armed <= 1'b0;
            vcnt  <= '0;
            tocnt <= '0;
         end else begin
            if (valley)             armed <= 1'b0;
            else if (en && zcd_hi)  armed <= 1'b1;
            if (valley && vcnt != VW'(VMAX)) vcnt <= vcnt + VW'(1);
            if (to_en && !zcd_lo) begin
               if (tocnt != TO_LAST) tocnt <= tocnt + TW'(1);
            end else begin
               tocnt <= '0;
            end
         end
      end
   end

   // R12
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valley && !clr) |=> !valley);

endmodule

// File: rtl/qrv_watchdog.sv
module qrv_watchdog #(
   parameter int unsigned WD_LL = 6875,
   parameter int unsigned WD_HL = 7750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic kick,
   input  logic hl,
   output logic expire
);
   localparam int unsigned WMAX = qrv_pkg::qrv_max(WD_LL, WD_HL);
   localparam int unsigned WW   = $clog2(WMAX + 1);

   logic [WW-1:0] wcnt;
   logic [WW-1:0] lim;

   if (WD_LL < 2 || WD_HL < 2) begin : g_bad
      $error("qrv_watchdog: limits must be at least 2 cycles");
   end

   if (WD_LL == WD_HL) begin : g_one
      assign lim = WW'(WD_LL);
   end else begin : g_two
      assign lim = hl ? WW'(WD_HL) : WW'(WD_LL);
   end

   assign expire = !clr && (wcnt >= lim - WW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              wcnt <= '0;
      else if (clr || kick)    wcnt <= '0;
      else if (!expire)        wcnt <= wcnt + WW'(1);
   end

   // R7
   wd_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !expire);

endmodule

// File: rtl/qrv_pin_strobe.sv
module qrv_pin_strobe #(
   parameter int unsigned N_ON  = 22,
   parameter int unsigned N_OFF = 41
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_on,
   input  logic go_off,
   output logic pin_gnd
);
   localparam int unsigned GW = $clog2(qrv_pkg::qrv_max(N_ON, N_OFF) + 1);

   logic [GW-1:0] gcnt;

   if (N_ON == 0 || N_OFF == 0) begin : g_bad
      $error("qrv_pin_strobe: both strobe lengths must be nonzero");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            gcnt <= '0;
      else if (go_on)        gcnt <= GW'(N_ON);
      else if (go_off)       gcnt <= GW'(N_OFF);
      else if (gcnt != '0)   gcnt <= gcnt - GW'(1);
   end

   assign pin_gnd = (gcnt != '0);

endmodule

// File: rtl/qr_valley_seq.sv
module qr_valley_seq
   import qrv_pkg::*;
#(
   parameter int unsigned ON_MAX_CYC      = 4500,
   parameter int unsigned LEB_CS_CYC      = 34,
   parameter int unsigned GND_ON_CYC      = 22,
   parameter int unsigned GND_OFF_CYC     = 41,
   parameter int unsigned BLANK_NORM_CYC  = 188,
   parameter int unsigned BLANK_START_CYC = 375,
   parameter int unsigned TIMEOUT_CYC     = 913,
   parameter int unsigned WD_LL_CYC       = 6875,
   parameter int unsigned WD_HL_CYC       = 7750,
   parameter int unsigned VALLEY_LL       = 1,
   parameter int unsigned VALLEY_HL       = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_trip,
   input  logic zcd_above_hi,
   input  logic zcd_above_lo,
   input  logic line_high,
   input  logic startup_req,
   output logic gate,
   output logic pin_gnd,
   output logic leb_cs,
   output logic leb_stop
);
   localparam int unsigned BW = $clog2(qrv_max(BLANK_NORM_CYC, BLANK_START_CYC) + 1);

   if (BLANK_NORM_CYC == 0 || BLANK_START_CYC < BLANK_NORM_CYC) begin : g_bad_blank
      $error("qr_valley_seq: blanking lengths out of order");
   end
   if (WD_LL_CYC <= BLANK_START_CYC + 1 || WD_HL_CYC <= BLANK_START_CYC + 1) begin : g_bad_wd
      $error("qr_valley_seq: watchdog must outlast startup blanking");
   end

   qrv_state_e st, st_nx;
   logic [BW-1:0] bcnt;
   logic [BW-1:0] blen;
   logic          start_mode;
   logic          hl_q;
   logic          on;
   logic          end_pulse;
   logic          blank_done;
   logic          go_on;
   logic          v_valley;
   logic          v_fire;
   logic          wd_expire;

   assign on         = (st == ST_ON);
   assign gate       = on;
   assign blen       = start_mode ? BW'(BLANK_START_CYC) : BW'(BLANK_NORM_CYC);
   assign blank_done = (st == ST_BLANK) && (bcnt >= blen - BW'(1));
   assign go_on      = (st == ST_WAIT) && (v_fire || wd_expire);

   always_comb begin
      st_nx = st;
      case (st)
         ST_ON:    if (end_pulse)  st_nx = ST_BLANK;
         ST_BLANK: if (blank_done) st_nx = ST_WAIT;
         ST_WAIT:  if (go_on)      st_nx = ST_ON;
         default:                  st_nx = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_WAIT;
         bcnt       <= '0;
         start_mode <= 1'b1;
         hl_q       <= 1'b0;
      end else begin
         st <= st_nx;
         if (st == ST_BLANK && !blank_done) bcnt <= bcnt + BW'(1);
         else                               bcnt <= '0;
         if (startup_req)                          start_mode <= 1'b1;
         else if (st == ST_WAIT && zcd_above_hi)   start_mode <= 1'b0;
         if (end_pulse) hl_q <= line_high;
      end
   end

   qrv_on_timer #(
      .ON_MAX   (ON_MAX_CYC),
      .LEB_CS   (LEB_CS_CYC),
      .LEB_STOP (GND_ON_CYC)
   ) u_on (
      .clk       (clk),
      .rst_n     (rst_n),
      .on        (on),
      .off_req   (cs_trip),
      .leb_cs    (leb_cs),
      .leb_stop  (leb_stop),
      .end_pulse (end_pulse)
   );

   qrv_valley_det #(
      .VAL_LL  (VALLEY_LL),
      .VAL_HL  (VALLEY_HL),
      .TIMEOUT (TIMEOUT_CYC)
   ) u_val (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (st == ST_WAIT),
      .clr    (on),
      .hl     (hl_q),
      .zcd_hi (zcd_above_hi),
      .zcd_lo (zcd_above_lo),
      .valley (v_valley),
      .fire   (v_fire)
   );

   qrv_watchdog #(
      .WD_LL (WD_LL_CYC),
      .WD_HL (WD_HL_CYC)
   ) u_wd (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (on),
      .kick   (v_valley),
      .hl     (hl_q),
      .expire (wd_expire)
   );

   qrv_pin_strobe #(
      .N_ON  (GND_ON_CYC),
      .N_OFF (GND_OFF_CYC)
   ) u_gnd (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_on   (go_on),
      .go_off  (end_pulse),
      .pin_gnd (pin_gnd)
   );

   // R4
   blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BLANK) |=> !gate);

   // R8
   gnd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> pin_gnd);

   // R8
   gnd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate) |-> pin_gnd);

   // R10
   leb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && leb_cs) |=> gate);

   // R2
   rise_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> $past(st == ST_WAIT));

endmodule

// File: tb/sim_qr_valley_seq.sv
`timescale 1ns/1ps
module sim_qr_valley_seq;
   localparam int ON_MAX = 40;
   localparam int LEB_CS = 6;
   localparam int GND_ON = 4;
   localparam int GND_OFF = 5;
   localparam int BL_N = 10;
   localparam int BL_S = 20;
   localparam int TO = 15;
   localparam int WDL = 60;
   localparam int WDH = 70;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_trip = 1'b0;
   logic zhi = 1'b0;
   logic zlo = 1'b0;
   logic lh = 1'b0;
   logic sreq = 1'b0;
   logic gate, pin_gnd, leb_cs, leb_stop;
   int checks = 0;
   int fails = 0;

   always #4 clk = ~clk;

   qr_valley_seq #(
      .ON_MAX_CYC(ON_MAX), .LEB_CS_CYC(LEB_CS), .GND_ON_CYC(GND_ON),
      .GND_OFF_CYC(GND_OFF), .BLANK_NORM_CYC(BL_N), .BLANK_START_CYC(BL_S),
      .TIMEOUT_CYC(TO), .WD_LL_CYC(WDL), .WD_HL_CYC(WDH),
      .VALLEY_LL(1), .VALLEY_HL(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cs_trip(cs_trip), .zcd_above_hi(zhi),
      .zcd_above_lo(zlo), .line_high(lh), .startup_req(sreq),
      .gate(gate), .pin_gnd(pin_gnd), .leb_cs(leb_cs), .leb_stop(leb_stop)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      while (gate !== 1'b1 && n < 2000) begin
         tick();
         n++;
      end
   endtask

   task automatic wait_fall();
      int k = 0;
      while (gate === 1'b1 && k < 2000) begin
         tick();
         k++;
      end
   endtask

   // called at the first low sample after a fall; ends d+1 samples later
   task automatic probe(input int d);
      repeat (d - 1) tick();
      zhi = 1'b1; zlo = 1'b1;
      tick();
      zhi = 1'b0; zlo = 1'b0;
      tick();
   endtask

   task automatic t_reset();
      int n;
      repeat (3) tick();
      chk("R1 gate in reset", int'(gate), 0);
      chk("R1 pin_gnd in reset", int'(pin_gnd), 0);
      chk("R1 leb_cs in reset", int'(leb_cs), 0);
      chk("R1 leb_stop in reset", int'(leb_stop), 0);
      rst_n = 1'b1;
      wait_rise(n);
      chk("R7 watchdog after reset", n, WDL);
   endtask

   task automatic t_shape();
      int w = 0, p = 0, lc = 0, ls = 0, pf = 0, n;
      while (gate === 1'b1 && w < 200) begin
         w++;
         if (pin_gnd) p++;
         if (leb_cs) lc++;
         if (leb_stop) ls++;
         tick();
      end
      chk("R9 on-time cap", w, ON_MAX);
      chk("R8 strobe after rise", p, GND_ON);
      chk("R10 leb_cs length", lc, LEB_CS);
      chk("R10 leb_stop length", ls, GND_ON);
      cs_trip = 1'b1;
      for (int i = 0; i < 8; i++) begin
         if (pin_gnd) pf++;
         if (i < 7) tick();
      end
      chk("R8 strobe after fall", pf, GND_OFF);
      wait_rise(n);
      chk("R7 watchdog after fall", 7 + n, WDL);
   endtask

   task automatic t_trip();
      int w = 0;
      while (gate === 1'b1 && w < 200) begin
         w++;
         tick();
      end
      chk("R10 trip width", w, LEB_CS + 1);
      repeat (5) tick();
      chk("R10 gate stays off", int'(gate), 0);
      repeat (BL_S - 5) tick();
      wait_fall();
   endtask

   task automatic t_start_blank();
      int n;
      // t_trip left the bench mid off-time; wait for the watchdog pulse
      wait_rise(n);
      wait_fall();
      probe(BL_S);
      chk("R5 arming on last startup blank cycle", int'(gate), 0);
      wait_rise(n);
      chk("R7 watchdog after blocked arm", BL_S + 1 + n, WDL);
      wait_fall();
      probe(BL_S + 1);
      chk("R2 R5 valley right after startup blank", int'(gate), 1);
   endtask

   task automatic t_norm_blank();
      int n;
      wait_fall();
      probe(BL_N + 1);
      chk("R5 normal blank after arming seen", int'(gate), 1);
      wait_fall();
      probe(BL_N);
      chk("R4 arming inside normal blank", int'(gate), 0);
      zlo = 1'b1;
      tick();
      zlo = 1'b0;
      tick();
      chk("R12 fall without arming", int'(gate), 0);
      wait_rise(n);
      chk("R7 watchdog with unarmed falls", BL_N + 3 + n, WDL);
   endtask

   task automatic t_high_line();
      int n;
      lh = 1'b1;
      wait_fall();
      probe(BL_N + 1);
      chk("R3 first valley skipped", int'(gate), 0);
      zhi = 1'b1; zlo = 1'b1;
      tick();
      zhi = 1'b0; zlo = 1'b0;
      tick();
      chk("R3 second valley turns on", int'(gate), 1);
      wait_fall();
      probe(BL_N + 1);
      chk("R3 valley one alone", int'(gate), 0);
      wait_rise(n);
      chk("R6 timeout after valley one", n, TO);
   endtask

   task automatic t_line_sample();
      int n;
      wait_fall();
      lh = 1'b0;
      wait_rise(n);
      chk("R11 R7 high-line watchdog kept", n, WDH);
      sreq = 1'b1;
      tick();
      sreq = 1'b0;
      wait_fall();
      probe(BL_N + 1);
      chk("R5 startup request lengthens blank", int'(gate), 0);
      wait_rise(n);
      chk("R11 low line resampled", BL_N + 2 + n, WDL);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_shape();
      t_trip();
      t_start_blank();
      t_norm_blank();
      t_high_line();
      t_line_sample();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule